// File: doc/BRIEF.md
# Three-Port General Register File

This block is the general-purpose register storage of a simple processor datapath. It holds thirty-two 32-bit words. Entry zero has no storage and always reads as zero. Two read outputs supply the ALU operands, and a third read output supplies the data for a memory store. All three read outputs are combinational.

One write port is updated on the falling edge of the clock. It is steered by instruction fields and a small control word:

- A 2-bit target selector picks the destination: the `rd` field, the `rt` field, or the fixed link entry 31.
- A write strobe gates the write.
- A 1-bit source selector picks the value to write: the ALU result or the data read from memory.

The store-data output shares its address with the second operand output. Instruction decode is done outside this block; only the raw register fields arrive here.

Top module: `gpr_bank3r`

## Requirements
- R1: `rst` high at a falling clock edge clears entries 1 to 31 to zero at that edge. After reset, every read returns 0.
- R2: Entry 0 always reads as 0 on every read output. A write aimed at entry 0 has no effect.
- R3: Read outputs are combinational:
  - `opa_data` returns the entry addressed by `fld_rs`.
  - `opb_data` and `st_data` both return the entry addressed by `fld_rt`.
- R4: With `wr_en`=1 and `dst_sel`=2'b00, the entry addressed by `fld_rd` takes the write value at the falling edge.
- R5: With `wr_en`=1 and `dst_sel`=2'b01, the entry addressed by `fld_rt` takes the write value at the falling edge.
- R6: With `wr_en`=1 and `dst_sel`=2'b10, entry 31 takes the write value, whatever `fld_rd` and `fld_rt` hold.
- R7: `dst_sel`=2'b11 performs no write, even with `wr_en`=1.
- R8: With `wr_en`=0, no entry changes.
- R9: The write value is `alu_res` when `wb_src`=0 and `mem_rdata` when `wb_src`=1.
- R10: There is no write-to-read bypass. Before the falling edge, a read of the entry being written returns its old value; after the edge, it returns the new value.
- R11: A write changes only the selected entry. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high clear of entries 1..31 |
| wr_en | input | 1 | Overall write strobe |
| dst_sel | input | 2 | Destination: 00 rd, 01 rt, 10 entry 31, 11 none |
| wb_src | input | 1 | Write value: 0 ALU result, 1 memory read data |
| fld_rs | input | 5 | First operand address |
| fld_rt | input | 5 | Second operand / store address, alternate destination |
| fld_rd | input | 5 | Primary destination address |
| alu_res | input | 32 | ALU result |
| mem_rdata | input | 32 | Memory read data |
| opa_data | output | 32 | Entry at fld_rs |
| opb_data | output | 32 | Entry at fld_rt |
| st_data | output | 32 | Store data, entry at fld_rt |

## Verification
Any corrupted entry is visible on a read output as soon as that entry is addressed. The bench therefore sweeps all 32 addresses after each scenario, and a wrong destination decode shows up as a changed bystander entry in the same sweep. A wrongly applied bypass or edge shows up within the same cycle: the bench reads the target entry just before the falling edge and again just after it. A swapped source multiplexer shows up at the first read following the write.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    typedef enum logic [1:0] {
        DST_RD   = 2'b00,
        DST_RT   = 2'b01,
        DST_LINK = 2'b10,
        DST_NONE = 2'b11
    } dst_sel_e;

    typedef enum logic {
        WB_ALU = 1'b0,
        WB_MEM = 1'b1
    } wb_src_e;
endpackage

// File: rtl/gpr_dest_decode.sv
module gpr_dest_decode
    import gpr_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             dst_sel,
    input  logic [AW-1:0]          fld_rd,
    input  logic [AW-1:0]          fld_rt,
    output logic [NUM_REGS-1:1]    wen
);
    localparam logic [AW-1:0] LINK_IDX = AW'(NUM_REGS - 1);

    logic [AW-1:0] dst_addr;
    logic          dst_ok;

    always_comb begin
        dst_addr = fld_rd;
        dst_ok   = 1'b1;
        unique case (dst_sel_e'(dst_sel))
            DST_RD:   dst_addr = fld_rd;
            DST_RT:   dst_addr = fld_rt;
            DST_LINK: dst_addr = LINK_IDX;
            DST_NONE: dst_ok   = 1'b0;
            default:  dst_ok   = 1'b0;
        endcase
    end

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_dec
        assign wen[i] = wr_en && dst_ok && (dst_addr == AW'(i));
    end

    assert_none_code_R7: assert property (@(negedge clk) disable iff (rst)
        (dst_sel == 2'b11) |-> (wen == '0));
    assert_strobe_low_R8: assert property (@(negedge clk) disable iff (rst)
        !wr_en |-> (wen == '0));
    assert_single_target_R11: assert property (@(negedge clk) disable iff (rst)
        $onehot0(wen));
    assert_link_target_R6: assert property (@(negedge clk) disable iff (rst)
        (wr_en && dst_sel == 2'b10) |-> wen[NUM_REGS-1]);
endmodule

// File: rtl/gpr_wdata_mux.sv
module gpr_wdata_mux
    import gpr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wb_src,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] wdata
);
    always_comb begin
        unique case (wb_src_e'(wb_src))
            WB_MEM:  wdata = mem_rdata;
            default: wdata = alu_res;
        endcase
    end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_REGS-1:1]                wen,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    rd_bus
);
    typedef struct packed {
        logic [NUM_REGS-1:1][DATA_W-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NUM_REGS; i++) begin
            if (wen[i]) st_d.regs[i] = wdata;
        end
        if (rst) st_d = '0;
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_bus[0] = '0;
        for (int i = 1; i < NUM_REGS; i++) rd_bus[i] = st_q.regs[i];
    end

    assert_reset_clears_R1: assert property (@(negedge clk)
        rst |=> (rd_bus == '0));

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_chk
        assert_write_lands_R4: assert property (@(negedge clk) disable iff (rst)
            wen[i] |=> (rd_bus[i] == $past(wdata)));
        assert_hold_value_R11: assert property (@(negedge clk) disable iff (rst)
            !wen[i] |=> $stable(rd_bus[i]));
    end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] rd_bus,
    input  logic [AW-1:0]                   addr,
    output logic [DATA_W-1:0]               data
);
    assign data = rd_bus[addr];
endmodule

// File: rtl/gpr_bank3r.sv
module gpr_bank3r
    import gpr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        dst_sel,
    input  logic              wb_src,
    input  logic [AW-1:0]     fld_rs,
    input  logic [AW-1:0]     fld_rt,
    input  logic [AW-1:0]     fld_rd,
    input  logic [DATA_W-1:0] alu_res,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] opa_data,
    output logic [DATA_W-1:0] opb_data,
    output logic [DATA_W-1:0] st_data
);
    localparam int NPORTS = 3;

    logic [NUM_REGS-1:1]             wen;
    logic [DATA_W-1:0]               wdata;
    logic [NUM_REGS-1:0][DATA_W-1:0] rd_bus;
    logic [NPORTS-1:0][AW-1:0]       port_addr;
    logic [NPORTS-1:0][DATA_W-1:0]   port_data;

    gpr_dest_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .clk(clk), .rst(rst), .wr_en(wr_en), .dst_sel(dst_sel),
        .fld_rd(fld_rd), .fld_rt(fld_rt), .wen(wen)
    );

    gpr_wdata_mux #(.DATA_W(DATA_W)) u_wmux (
        .wb_src(wb_src), .alu_res(alu_res), .mem_rdata(mem_rdata), .wdata(wdata)
    );

    gpr_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk(clk), .rst(rst), .wen(wen), .wdata(wdata), .rd_bus(rd_bus)
    );

    assign port_addr[0] = fld_rs;
    assign port_addr[1] = fld_rt;
    assign port_addr[2] = fld_rt;

    for (genvar p = 0; p < NPORTS; p++) begin : g_rport
        gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rp (
            .rd_bus(rd_bus), .addr(port_addr[p]), .data(port_data[p])
        );
    end

    assign opa_data = port_data[0];
    assign opb_data = port_data[1];
    assign st_data  = port_data[2];

    assert_zero_entry_R2: assert property (@(negedge clk) disable iff (rst)
        (fld_rs == '0) |-> (opa_data == '0));
    assert_store_matches_R3: assert property (@(negedge clk) disable iff (rst)
        st_data == opb_data);
endmodule

// File: tb/gpr_bank3r_tb_top.sv
`timescale 1ns/1ps
module gpr_bank3r_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  dst_sel = 2'b11;
    logic        wb_src = 1'b0;
    logic [4:0]  fld_rs = '0, fld_rt = '0, fld_rd = '0;
    logic [31:0] alu_res = '0, mem_rdata = '0;
    logic [31:0] opa_data, opb_data, st_data;

    logic [31:0] model [32];
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpr_bank3r dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .dst_sel(dst_sel), .wb_src(wb_src),
        .fld_rs(fld_rs), .fld_rt(fld_rt), .fld_rd(fld_rd),
        .alu_res(alu_res), .mem_rdata(mem_rdata),
        .opa_data(opa_data), .opb_data(opb_data), .st_data(st_data)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sweep(string req);
        for (int i = 0; i < 32; i++) begin
            fld_rs = 5'(i);
            fld_rt = 5'(31 - i);
            #0.2;
            check(req, opa_data, model[i]);
            check(req, opb_data, model[31 - i]);
            check(req, st_data,  model[31 - i]);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic src, logic [4:0] rd, logic [4:0] rt,
                      logic [31:0] a, logic [31:0] m, logic en);
        logic [31:0] v;
        int tgt;
        wr_en = en; dst_sel = sel; wb_src = src;
        fld_rd = rd; fld_rt = rt; alu_res = a; mem_rdata = m;
        @(negedge clk); #1;
        wr_en = 1'b0;
        v = src ? m : a;
        tgt = (sel == 2'b00) ? int'(rd) : (sel == 2'b01) ? int'(rt) : (sel == 2'b10) ? 31 : -1;
        if (en && tgt > 0) model[tgt] = v;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        rst = 1'b0;
        for (int i = 0; i < 32; i++) model[i] = '0;
    endtask

    task automatic t_reset;
        do_reset();
        sweep("R1 reset clear");
    endtask

    task automatic t_fill_rd;
        for (int i = 1; i < 32; i++)
            wr(2'b00, 1'b0, 5'(i), 5'(0), 32'hA500_0000 + 32'(i * 3), 32'hDEAD_0000, 1'b1);
        sweep("R4 R9 R3 rd alu fill");
    endtask

    task automatic t_mem_src;
        wr(2'b00, 1'b1, 5'd7, 5'd0, 32'h1111_1111, 32'h7777_0007, 1'b1);
        fld_rs = 5'd7; #0.2;
        check("R9 mem source", opa_data, 32'h7777_0007);
        sweep("R9 R11 after mem write");
    endtask

    task automatic t_rt_dest;
        wr(2'b01, 1'b0, 5'd3, 5'd12, 32'h0C0C_1212, 32'h0, 1'b1);
        fld_rt = 5'd12; #0.2;
        check("R5 rt dest", opb_data, 32'h0C0C_1212);
        sweep("R5 R11 rt dest");
    endtask

    task automatic t_link;
        wr(2'b10, 1'b1, 5'd4, 5'd5, 32'h0, 32'h0000_4444, 1'b1);
        fld_rs = 5'd31; #0.2;
        check("R6 link dest", opa_data, 32'h0000_4444);
        sweep("R6 R11 link only");
    endtask

    task automatic t_none_code;
        wr(2'b11, 1'b0, 5'd9, 5'd10, 32'hBAD0_BAD0, 32'hBAD1_BAD1, 1'b1);
        sweep("R7 unused code no write");
    endtask

    task automatic t_wen_low;
        wr(2'b00, 1'b0, 5'd20, 5'd21, 32'hFEED_F00D, 32'h0, 1'b0);
        wr(2'b10, 1'b1, 5'd20, 5'd21, 32'h0, 32'hFEED_F00D, 1'b0);
        sweep("R8 strobe low no write");
    endtask

    task automatic t_zero;
        wr(2'b00, 1'b0, 5'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 1'b1);
        wr(2'b01, 1'b1, 5'd1, 5'd0, 32'h0, 32'hFFFF_FFFF, 1'b1);
        fld_rs = 5'd0; fld_rt = 5'd0; #0.2;
        check("R2 zero entry opa", opa_data, 32'h0);
        check("R2 zero entry st", st_data, 32'h0);
        sweep("R2 zero write discarded");
    endtask

    task automatic t_no_bypass;
        wr_en = 1'b1; dst_sel = 2'b00; wb_src = 1'b0;
        fld_rd = 5'd5; alu_res = 32'h5A5A_0505;
        fld_rs = 5'd5; fld_rt = 5'd5;
        #1;
        check("R10 old value before edge", opa_data, model[5]);
        check("R10 old value before edge st", st_data, model[5]);
        @(negedge clk); #0.5;
        check("R10 new value after edge", opa_data, 32'h5A5A_0505);
        wr_en = 1'b0;
        model[5] = 32'h5A5A_0505;
    endtask

    task automatic t_reset_mid;
        do_reset();
        sweep("R1 clear after use");
    endtask

    initial begin
        #(200000.0 * 5.0);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_rd();
        t_mem_src();
        t_rt_dest();
        t_link();
        t_none_code();
        t_wen_low();
        t_zero();
        t_no_bypass();
        sweep("R10 R11 after bypass check");
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule